// File: doc/BRIEF.md
# Hiccup Overload Guard

This block supervises the enable of a power output stage. It takes four inputs: an overcurrent indication from an analog clamp, which arrives unsynchronised, a thermal-trip indication, a protection-mode select and a one-cycle strobe that marks the end of power-on soft-start. It drives the output enable and two status flags, one for overload and one for overtemperature. All timing is counted in pulses of a millisecond tick input.

In dynamic mode a persistent overload starts a retry cycle. The output is switched off for a long window, then switched back on for a short trial window during which only the external clamp limits the current. The cycle repeats until a trial window ends with the overload gone. In static mode the output stays on and the overload flag only mirrors the clamp. A typical use is to power up a capacitive load in static mode and change to dynamic mode once the load has charged. The thermal path overrides the output enable on its own, independently of the overload logic.

Top module: `hiccup_guard`

## Requirements
- R1: In dynamic mode (`static_sel`=0), when `oc_raw` rises, `out_en` goes low and `ovl_flag` goes high on the third rising clock edge. Two edges are spent in the synchroniser and one in the state register.
- R2: The output stays off for exactly OFF_MS tick pulses. `out_en` returns high on the edge that samples the OFF_MS-th tick.
- R3: The trial window lasts ON_MS ticks. If the synchronised overcurrent is high on the edge that samples the ON_MS-th tick, `out_en` goes low again for a further OFF_MS ticks and `ovl_flag` stays high.
- R4: If the synchronised overcurrent is low at the end of the trial window, the block returns to normal. `out_en` stays high and `ovl_flag` goes low on that edge. `ovl_flag` stays high until that edge.
- R5: In static mode (`static_sel`=1), `out_en` is never dropped for overload. `ovl_flag` follows `oc_raw` with a latency of three edges, both when it rises and when it falls.
- R6: On the edge after `ss_done`=1 is sampled, `ovl_flag` reads 0 in either mode, and any retry cycle in progress is abandoned so the output is enabled.
- R7: One edge after `therm_trip` is sampled high, `ot_flag`=1 and `out_en`=0. One edge after it is sampled low, both are released. The overload state and timers continue undisturbed meanwhile.
- R8: A change from static to dynamic mode while overcurrent is present starts a full OFF_MS off window on the next edge. A change from dynamic to static mode mid-cycle re-enables the output on the next edge and discards the timer, so a later retry cycle starts from zero.
- R9: While `rst_n` is low, `out_en`=1, `ovl_flag`=0 and `ot_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| oc_raw | input | 1 | Clamp-active overcurrent indication, asynchronous |
| therm_trip | input | 1 | Junction over-temperature indication |
| static_sel | input | 1 | 1 = static protection, 0 = dynamic retry |
| ss_done | input | 1 | One-cycle strobe at end of soft-start |
| out_en | output | 1 | Output stage enable |
| ovl_flag | output | 1 | Overload status flag |
| ot_flag | output | 1 | Overtemperature status flag |

## Verification
The hardest states to reach are a retry cycle that is partly consumed and then interrupted, whether by a mode change, a soft-start strobe or a thermal trip. Each interruption must be shown to restart or preserve the timer as specified. The bench drives every tick pulse by hand, so it knows the exact count inside each window. It can therefore interrupt a window two ticks in and then prove the restart: after the retry cycle begins again, the full OFF_MS minus one ticks must still leave the output off. For the thermal case, the bench lets the off window expire while the trip holds the output low. It then shows that the trial window is already running when the trip releases.

// File: rtl/hg_pkg.sv
package hg_pkg;
  typedef enum logic [1:0] {
    HG_NORMAL = 2'd0,
    HG_OFF    = 2'd1,
    HG_TRY    = 2'd2
  } hg_state_e;
endpackage

// File: rtl/hg_sync.sv
module hg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[i] <= 1'b0;
          else        sr[i] <= sr[i-1];
        end
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/hg_timer.sv
module hg_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] last,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = run && tick && (cnt_q == last);
  assign cnt_en = clr || (run && tick);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hg_fsm.sv
module hg_fsm
  import hg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      oc_s,
  input  logic      static_sel,
  input  logic      ss_done,
  input  logic      t_done,
  output hg_state_e state,
  output logic      t_clr,
  output logic      flag,
  output logic      drv_en
);
  hg_state_e st_q, st_d;
  logic      flg_q, flg_d;

  always_comb begin
    st_d  = st_q;
    flg_d = flg_q;
    if (ss_done) begin
      st_d  = HG_NORMAL;
      flg_d = 1'b0;
    end else if (static_sel) begin
      st_d  = HG_NORMAL;
      flg_d = oc_s;
    end else begin
      case (st_q)
        HG_NORMAL: begin
          if (oc_s) begin
            st_d  = HG_OFF;
            flg_d = 1'b1;
          end else begin
            flg_d = 1'b0;
          end
        end
        HG_OFF: begin
          if (t_done) st_d = HG_TRY;
        end
        HG_TRY: begin
          if (t_done) begin
            if (oc_s) begin
              st_d = HG_OFF;
            end else begin
              st_d  = HG_NORMAL;
              flg_d = 1'b0;
            end
          end
        end
        default: begin
          st_d  = HG_NORMAL;
          flg_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HG_NORMAL;
      flg_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      flg_q <= flg_d;
    end
  end

  assign state  = st_q;
  assign t_clr  = (st_d != st_q);
  assign flag   = flg_q;
  assign drv_en = (st_q != HG_OFF);
endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hg_pkg::*;
#(
  parameter int OFF_MS      = 900,
  parameter int ON_MS       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic oc_raw,
  input  logic therm_trip,
  input  logic static_sel,
  input  logic ss_done,
  output logic out_en,
  output logic ovl_flag,
  output logic ot_flag
);
  localparam int MAX_MS   = (OFF_MS > ON_MS) ? OFF_MS : ON_MS;
  localparam int CNT_W    = $clog2(MAX_MS + 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_MS - 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_MS - 1);

  logic             oc_s;
  logic             t_done;
  logic             t_clr;
  logic             t_run;
  logic [CNT_W-1:0] t_last;
  logic             drv_en;
  logic             ot_q;
  hg_state_e        state;

  hg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (oc_raw),
    .q     (oc_s)
  );

  assign t_run  = (state != HG_NORMAL);
  assign t_last = (state == HG_OFF) ? OFF_LAST : ON_LAST;

  hg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (t_clr),
    .run   (t_run),
    .tick  (ms_tick),
    .last  (t_last),
    .done  (t_done)
  );

  hg_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_s       (oc_s),
    .static_sel (static_sel),
    .ss_done    (ss_done),
    .t_done     (t_done),
    .state      (state),
    .t_clr      (t_clr),
    .flag       (ovl_flag),
    .drv_en     (drv_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ot_q <= 1'b0;
    else        ot_q <= therm_trip;
  end

  assign ot_flag = ot_q;
  assign out_en  = drv_en && !ot_q;
endmodule

// File: rtl/hiccup_guard_chk.sv
module hiccup_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic therm_trip,
  input logic static_sel,
  input logic ss_done,
  input logic out_en,
  input logic ovl_flag,
  input logic ot_flag,
  input logic drv_en
);
  AST_OT_BLOCKS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |-> !out_en); // R7

  AST_OT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    therm_trip |=> ot_flag); // R7

  AST_OT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_trip |=> !ot_flag); // R7

  AST_STATIC_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (static_sel && $past(static_sel) && !ot_flag) |-> out_en); // R5

  AST_SS_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |=> !ovl_flag); // R6

  AST_OFF_MEANS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!static_sel && !drv_en) |-> ovl_flag); // R1

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en && !ms_tick && !static_sel && !ss_done) |=> !drv_en); // R2
endmodule

bind hiccup_guard hiccup_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ms_tick    (ms_tick),
  .therm_trip (therm_trip),
  .static_sel (static_sel),
  .ss_done    (ss_done),
  .out_en     (out_en),
  .ovl_flag   (ovl_flag),
  .ot_flag    (ot_flag),
  .drv_en     (drv_en)
);

// File: tb/hiccup_guard_bench.sv
module hiccup_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_N      = 9;
  localparam int ON_N       = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ms_tick, oc_raw, therm_trip, static_sel, ss_done;
  logic out_en, ovl_flag, ot_flag;
  int   n_chk  = 0;
  int   n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_guard #(.OFF_MS(OFF_N), .ON_MS(ON_N), .SYNC_STAGES(2)) u_hiccup_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .oc_raw     (oc_raw),
    .therm_trip (therm_trip),
    .static_sel (static_sel),
    .ss_done    (ss_done),
    .out_en     (out_en),
    .ovl_flag   (ovl_flag),
    .ot_flag    (ot_flag)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      cyc(1);
      ms_tick = 1'b0;
    end
  endtask

  task automatic t_reset(input logic mode);
    ms_tick = 0; oc_raw = 0; therm_trip = 0; ss_done = 0; static_sel = mode;
    rst_n = 1'b0;
    cyc(1);
    chk("R9", "out_en in reset", out_en, 1'b1);
    chk("R9", "ovl_flag in reset", ovl_flag, 1'b0);
    chk("R9", "ot_flag in reset", ot_flag, 1'b0);
    cyc(1);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_dynamic;
    t_reset(1'b0);
    oc_raw = 1'b1;
    cyc(2);
    chk("R1", "out_en after 2 edges", out_en, 1'b1);
    cyc(1);
    chk("R1", "out_en after 3 edges", out_en, 1'b0);
    chk("R1", "ovl_flag after 3 edges", ovl_flag, 1'b1);
    cyc(4);
    chk("R2", "no tick keeps off", out_en, 1'b0);
    tick_n(OFF_N - 1);
    chk("R2", "off before last tick", out_en, 1'b0);
    tick_n(1);
    chk("R2", "on after last off tick", out_en, 1'b1);
    tick_n(ON_N - 1);
    chk("R3", "on within trial", out_en, 1'b1);
    tick_n(1);
    chk("R3", "off again after failed trial", out_en, 1'b0);
    chk("R3", "flag held", ovl_flag, 1'b1);
    tick_n(OFF_N - 1);
    chk("R3", "second off window full", out_en, 1'b0);
    tick_n(1);
    chk("R3", "second trial on", out_en, 1'b1);
    oc_raw = 1'b0;
    cyc(3);
    tick_n(ON_N - 1);
    chk("R4", "flag high until trial end", ovl_flag, 1'b1);
    tick_n(1);
    chk("R4", "flag low after clean trial", ovl_flag, 1'b0);
    chk("R4", "out on after clean trial", out_en, 1'b1);
    tick_n(OFF_N + ON_N);
    chk("R4", "normal stays on", out_en, 1'b1);
  endtask

  task automatic t_static;
    t_reset(1'b1);
    oc_raw = 1'b1;
    cyc(2);
    chk("R5", "flag after 2 edges", ovl_flag, 1'b0);
    cyc(1);
    chk("R5", "flag after 3 edges", ovl_flag, 1'b1);
    tick_n(2 * (OFF_N + ON_N));
    chk("R5", "out stays on static", out_en, 1'b1);
    chk("R5", "flag still high", ovl_flag, 1'b1);
    oc_raw = 1'b0;
    cyc(2);
    chk("R5", "flag before fall latency", ovl_flag, 1'b1);
    cyc(1);
    chk("R5", "flag follows fall", ovl_flag, 1'b0);
  endtask

  task automatic t_softstart;
    t_reset(1'b0);
    oc_raw = 1'b1;
    cyc(3);
    tick_n(2);
    chk("R6", "in off window", out_en, 1'b0);
    oc_raw = 1'b0;
    cyc(3);
    ss_done = 1'b1;
    cyc(1);
    ss_done = 1'b0;
    chk("R6", "flag cleared by strobe", ovl_flag, 1'b0);
    chk("R6", "retry abandoned", out_en, 1'b1);
    static_sel = 1'b1;
    oc_raw = 1'b1;
    cyc(4);
    chk("R6", "static flag up", ovl_flag, 1'b1);
    ss_done = 1'b1;
    cyc(1);
    ss_done = 1'b0;
    chk("R6", "static flag cleared by strobe", ovl_flag, 1'b0);
    cyc(1);
    chk("R5", "static flag returns", ovl_flag, 1'b1);
  endtask

  task automatic t_thermal;
    t_reset(1'b0);
    therm_trip = 1'b1;
    cyc(1);
    chk("R7", "ot_flag set", ot_flag, 1'b1);
    chk("R7", "out off on trip", out_en, 1'b0);
    chk("R7", "ovl untouched", ovl_flag, 1'b0);
    therm_trip = 1'b0;
    cyc(1);
    chk("R7", "ot_flag clear", ot_flag, 1'b0);
    chk("R7", "out back on", out_en, 1'b1);
    oc_raw = 1'b1;
    cyc(3);
    therm_trip = 1'b1;
    tick_n(OFF_N);
    chk("R7", "held off during trip", out_en, 1'b0);
    therm_trip = 1'b0;
    cyc(1);
    chk("R7", "trial already running", out_en, 1'b1);
    chk("R7", "ovl still set", ovl_flag, 1'b1);
    oc_raw = 1'b0;
    cyc(3);
    tick_n(ON_N);
    chk("R7", "clean finish after trip", ovl_flag, 1'b0);
  endtask

  task automatic t_modes;
    t_reset(1'b1);
    oc_raw = 1'b1;
    cyc(3);
    chk("R8", "static on with overload", out_en, 1'b1);
    static_sel = 1'b0;
    cyc(1);
    chk("R8", "dynamic takes effect", out_en, 1'b0);
    tick_n(OFF_N - 1);
    chk("R8", "full off window", out_en, 1'b0);
    tick_n(1);
    chk("R8", "trial after full window", out_en, 1'b1);
    tick_n(ON_N);
    tick_n(2);
    chk("R8", "mid off window", out_en, 1'b0);
    static_sel = 1'b1;
    cyc(1);
    chk("R8", "static re-enables", out_en, 1'b1);
    static_sel = 1'b0;
    cyc(1);
    chk("R8", "new off window", out_en, 1'b0);
    tick_n(OFF_N - 1);
    chk("R8", "timer restarted", out_en, 1'b0);
    tick_n(1);
    chk("R8", "restarted window ends", out_en, 1'b1);
  endtask

  initial begin
    cyc(200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ms_tick = 0; oc_raw = 0; therm_trip = 0; static_sel = 0; ss_done = 0;
    cyc(1);
    t_dynamic();
    t_static();
    t_softstart();
    t_thermal();
    t_modes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule